// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It takes the memory from power-up to normal operation. After reset it holds the clock enable low through a stabilization delay. It then raises the clock enable and issues a fixed run of commands on the chip-select, row-strobe, column-strobe and write-enable pins, the bank address and the address bus. Between commands it fills every cycle with no-operation commands. When the run is complete it raises a ready flag, and from then on the normal traffic controller can take over the command bus.

All timing is given in clock cycles through module parameters, except the stabilization delay, which is a time in microseconds. The block converts it to cycles with the clock frequency parameter. The burst length, burst type and read latency codes that go into the mode register are also parameters.

The command run is fixed:
1. Precharge all banks.
2. Load the extended mode register, which enables the DLL.
3. Load the base mode register with the DLL-reset bit set.
4. Wait for the DLL to lock.
5. Precharge all banks again.
6. Issue two auto refreshes.
7. Reload the base mode register with the DLL-reset bit cleared.

Top module: `ddr_init_seq_top`

## Requirements
- R1: After reset is released, `cke_o` stays low, the pins `{cs_no,ras_no,cas_no,we_no}` carry NOP (`4'b0111`), `ba_o` and `addr_o` are zero and `ready_o` is low for exactly STAB_US*CLK_MHZ clock cycles.
- R2: The first cycle with `cke_o` high carries a NOP. `cke_o` never falls again until reset.
- R3: After that NOP the block issues exactly seven commands, in this order: PRECHARGE (`4'b0010`), LOAD MODE (`4'b0000`), LOAD MODE, PRECHARGE, AUTO REFRESH (`4'b0001`), AUTO REFRESH, LOAD MODE.
- R4: Both PRECHARGE commands drive address bit 10 high and every other address and bank bit low, so that all banks are selected.
- R5: The first LOAD MODE drives bank address 1 (`ba_o = 2'b01`) and an all-zero address. Bit 0 low enables the DLL.
- R6: The second LOAD MODE drives bank address 0 and an address made up as follows: bits 2:0 = BL_CODE, bit 3 = BT_SEL, bits 6:4 = CL_CODE, bit 8 = 1 (DLL reset). Bit 7 and bits 11:9 are 0.
- R7: The final LOAD MODE drives bank address 0 and the same address as R6, except that bit 8 is 0.
- R8: The spacing between command cycles is as follows. From the cke-rise NOP to the first PRECHARGE is 1 cycle. After each PRECHARGE it is T_RP cycles. After the extended-register load it is T_MRD cycles. After the DLL-reset load it is max(T_MRD, DLL_LOCK) cycles. After each AUTO REFRESH it is T_RFC cycles. Every cycle between two commands is a NOP.
- R9: `ready_o` rises exactly T_MRD cycles after the final LOAD MODE. It then stays high, with `cke_o` high and NOP on the pins.
- R10: Asserting `rst_ni` at any point, including in the middle of the run, returns the outputs at once to the R1 state. Releasing it restarts the full run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_o | output | 1 | Memory clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address / mode register select |
| addr_o | output | ADDR_W | Address bus / mode register opcode |
| ready_o | output | 1 | Initialization complete |

## Verification
Each output changes on the clock edge that follows the timer expiring, through a single register stage. A command that is due N cycles after the previous one therefore appears exactly N edges later, and `cke_o` rises on edge STAB_US*CLK_MHZ after reset release.

The bench counts edges from the release of reset. It derives the cycle of every event from the parameters, and it compares all pins against that schedule at every falling edge, half a period after the edge that updated them. The mid-run reset is checked between edges, so the asynchronous clear is seen without waiting for a clock.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_STAB, ST_CKE, ST_PRE1, ST_EMR, ST_MR_RST,
    ST_PRE2, ST_REF1, ST_REF2, ST_MR_RUN, ST_DONE
  } step_e;

  typedef enum logic [2:0] {
    OP_NOP, OP_PRE_ALL, OP_LMR_EXT, OP_LMR_DLL, OP_REF, OP_LMR_RUN
  } op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP = 4'b0111;
  localparam logic [3:0] PINS_PRE = 4'b0010;
  localparam logic [3:0] PINS_REF = 4'b0001;
  localparam logic [3:0] PINS_LMR = 4'b0000;

  function automatic op_e step_op(step_e s);
    case (s)
      ST_PRE1, ST_PRE2: return OP_PRE_ALL;
      ST_EMR:           return OP_LMR_EXT;
      ST_MR_RST:        return OP_LMR_DLL;
      ST_REF1, ST_REF2: return OP_REF;
      ST_MR_RUN:        return OP_LMR_RUN;
      default:          return OP_NOP;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              remain_q <= CNT_W'(INIT);
    else if (load_i)          remain_q <= val_i;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign done_o = (remain_q == '0);

  // R8
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (remain_q == $past(val_i)));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned STAB_CYC = 20000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RFC    = 10,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned DLL_LOCK = 200,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output op_e              op_o,
  output logic             cke_o,
  output logic             ready_o
);

  localparam int unsigned LOCK_W = max2(T_MRD, DLL_LOCK);

  step_e step_q, step_nxt;
  op_e   op_q;
  logic  cke_q, rdy_q, adv;

  // distance from a step's command to the next command, minus one
  function automatic logic [CNT_W-1:0] gap_of(step_e s);
    int unsigned w;
    case (s)
      ST_STAB:           w = STAB_CYC;
      ST_PRE1, ST_PRE2:  w = T_RP;
      ST_EMR, ST_MR_RUN: w = T_MRD;
      ST_MR_RST:         w = LOCK_W;
      ST_REF1, ST_REF2:  w = T_RFC;
      default:           w = 1;
    endcase
    return CNT_W'(w - 1);
  endfunction

  always_comb begin
    adv        = tmr_done_i && (step_q != ST_DONE);
    step_nxt   = step_e'(4'(step_q) + 4'd1);
    tmr_load_o = adv;
    tmr_val_o  = gap_of(step_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_STAB;
      op_q   <= OP_NOP;
      cke_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else if (adv) begin
      step_q <= step_nxt;
      op_q   <= step_op(step_nxt);
      cke_q  <= 1'b1;
      rdy_q  <= (step_nxt == ST_DONE);
    end else begin
      op_q   <= OP_NOP;
    end
  end

  assign op_o    = op_q;
  assign cke_o   = cke_q;
  assign ready_o = rdy_q;

  // R8
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_done_i |=> $stable(step_q));

  // R8
  cmd_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_NOP) |-> $past(tmr_done_i));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BA_W    = 2,
  parameter logic [2:0]  BL_CODE = 3'b010,
  parameter logic        BT_SEL  = 1'b0,
  parameter logic [2:0]  CL_CODE = 3'b010
) (
  input  op_e              op_i,
  output logic [3:0]       pins_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] mode_w;

  always_comb begin
    mode_w      = '0;
    mode_w[2:0] = BL_CODE;
    mode_w[3]   = BT_SEL;
    mode_w[6:4] = CL_CODE;

    pins_o = PINS_NOP;
    ba_o   = '0;
    addr_o = '0;
    case (op_i)
      OP_PRE_ALL: begin
        pins_o     = PINS_PRE;
        addr_o[10] = 1'b1;
      end
      OP_LMR_EXT: begin
        pins_o = PINS_LMR;
        ba_o   = BA_W'(1);
      end
      OP_LMR_DLL: begin
        pins_o    = PINS_LMR;
        addr_o    = mode_w;
        addr_o[8] = 1'b1;
      end
      OP_REF:     pins_o = PINS_REF;
      OP_LMR_RUN: begin
        pins_o = PINS_LMR;
        addr_o = mode_w;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_init_seq_top.sv
module ddr_init_seq_top
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned STAB_US  = 200,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RFC    = 10,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned DLL_LOCK = 200,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BA_W     = 2,
  parameter logic [2:0]  BL_CODE  = 3'b010,
  parameter logic        BT_SEL   = 1'b0,
  parameter logic [2:0]  CL_CODE  = 3'b010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);

  localparam int unsigned STAB_CYC = STAB_US * CLK_MHZ;
  localparam int unsigned MAX_GAP  =
    max2(STAB_CYC, max2(DLL_LOCK, max2(T_RFC, max2(T_RP, T_MRD))));
  localparam int unsigned CNT_W    = $clog2(MAX_GAP + 1);

  logic             tmr_done, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  op_e              op;
  logic [3:0]       pins;

  ddr_init_timer #(.CNT_W(CNT_W), .INIT(STAB_CYC - 1)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  ddr_init_seq #(
    .STAB_CYC (STAB_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .DLL_LOCK (DLL_LOCK), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .op_o       (op),
    .cke_o      (cke_o),
    .ready_o    (ready_o)
  );

  ddr_init_cmd_enc #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .BL_CODE(BL_CODE), .BT_SEL(BT_SEL), .CL_CODE(CL_CODE)
  ) u_enc (
    .op_i   (op),
    .pins_o (pins),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  assign {cs_no, ras_no, cas_no, we_no} = pins;

  // R1
  stab_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (pins == PINS_NOP && !ready_o));

  // R2
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o && cke_o && pins == PINS_NOP));

  // R4
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == PINS_PRE) |-> addr_o[10]);

  // R5
  lmr_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == PINS_LMR) |-> (ba_o[BA_W-1:1] == '0));

endmodule

// File: tb/ddr_init_seq_top_test.sv
module ddr_init_seq_top_test;

  localparam int CLK_MHZ  = 2;
  localparam int STAB_US  = 200;
  localparam int T_RP     = 3;
  localparam int T_RFC    = 7;
  localparam int T_MRD    = 2;
  localparam int DLL_LOCK = 200;

  localparam int STAB   = STAB_US * CLK_MHZ;
  localparam int K_PRE1 = STAB + 1;
  localparam int K_EMR  = K_PRE1 + T_RP;
  localparam int K_MRR  = K_EMR + T_MRD;
  localparam int K_PRE2 = K_MRR + ((DLL_LOCK > T_MRD) ? DLL_LOCK : T_MRD);
  localparam int K_REF1 = K_PRE2 + T_RP;
  localparam int K_REF2 = K_REF1 + T_RFC;
  localparam int K_MRN  = K_REF2 + T_RFC;
  localparam int K_RDY  = K_MRN + T_MRD;

  // BL=8 (011), interleaved, CL code 110
  localparam logic [11:0] MODE_RUN = 12'h06B;
  localparam logic [11:0] MODE_RST = 12'h16B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, rdy;
  logic [1:0]  ba;
  logic [11:0] addr;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ddr_init_seq_top #(
    .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK), .ADDR_W(12), .BA_W(2),
    .BL_CODE(3'b011), .BT_SEL(1'b1), .CL_CODE(3'b110)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n),
    .cas_no(cas_n), .we_no(we_n), .ba_o(ba), .addr_o(addr), .ready_o(rdy)
  );

  task automatic compare(string tag, int k, logic e_cke, logic [3:0] e_pins,
                         logic [1:0] e_ba, logic [11:0] e_addr, logic e_rdy);
    logic [3:0] pins;
    pins = {cs_n, ras_n, cas_n, we_n};
    tests++;
    if (cke !== e_cke || pins !== e_pins || ba !== e_ba || addr !== e_addr || rdy !== e_rdy) begin
      fails++;
      $display("FAIL %s k=%0d cke=%b/%b pins=%b/%b ba=%0d/%0d addr=%h/%h rdy=%b/%b",
               tag, k, cke, e_cke, pins, e_pins, ba, e_ba, addr, e_addr, rdy, e_rdy);
    end
  endtask

  // expected outputs k clock edges after reset release
  task automatic check_cycle(int k);
    string tag = "R8";
    logic [3:0]  e_pins = 4'b0111;
    logic [1:0]  e_ba = 2'd0;
    logic [11:0] e_addr = 12'h000;
    if (k < STAB) tag = "R1";
    else if (k == STAB) tag = "R2";
    else if (k >= K_RDY) tag = "R9";
    if (k == K_PRE1 || k == K_PRE2) begin
      tag = "R4"; e_pins = 4'b0010; e_addr = 12'h400;
    end else if (k == K_EMR) begin
      tag = "R5"; e_pins = 4'b0000; e_ba = 2'd1;
    end else if (k == K_MRR) begin
      tag = "R6"; e_pins = 4'b0000; e_addr = MODE_RST;
    end else if (k == K_REF1 || k == K_REF2) begin
      tag = "R3"; e_pins = 4'b0001;
    end else if (k == K_MRN) begin
      tag = "R7"; e_pins = 4'b0000; e_addr = MODE_RUN;
    end
    compare(tag, k, (k >= STAB), e_pins, e_ba, e_addr, (k >= K_RDY));
  endtask

  task automatic run_to(int last);
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      check_cycle(k);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R10", 0, 1'b0, 4'b0111, 2'd0, 12'h000, 1'b0);
    rst_n = 1'b1;
    check_cycle(0);
    run_to(K_MRR + 50);
    // R10: asynchronous reset mid-run, during the DLL lock wait
    #2 rst_n = 1'b0;
    #1 compare("R10", -1, 1'b0, 4'b0111, 2'd0, 12'h000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    check_cycle(0);
    run_to(K_RDY + 40);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule